// File: doc/BRIEF.md
# System Control Register Bank

This block holds the privileged control registers that a processor core uses for fast system-call entry, for segment bases, for extended feature control and for the interrupt controller base address. The core reaches them through a single port. Each access presents an address, a 64-bit write value and a read or write strobe, together with the current privilege level, a real-mode flag and a paging-enabled flag.

Every register has its own write rule. Depending on the register, a write may be truncated to 32 bits, rejected when its address is not canonical, rejected when it touches unsupported feature bits, or rejected when it would change the long-mode enable bit while paging is on. Any rule violation raises a one-cycle fault, and the register keeps its old value. An accepted write to the interrupt controller base produces a one-cycle relocation pulse, so that neighbouring logic can move the controller window.

Top module: `sysreg_bank`

## Requirements
- R1: When real_mode is 0 and priv_lvl is not 0, any read or write faults. The read returns no data and the write changes nothing.
- R2: The fast-call code-segment register keeps only bits 31:0 of a write. It reads back with bits 63:32 equal to zero.
- R3: Writes to the fast-call stack pointer, the fast-call instruction pointer, the long and compatibility call targets, and the FS, GS and kernel-GS bases fault unless the value is canonical. A value is canonical when bits 63 down to 47 are all equal.
- R4: The legacy call target stores the full 64-bit value. The flag mask and the auxiliary timestamp register keep bits 31:0 and zero the upper half.
- R5: A write to the feature register faults in two cases: it sets a bit outside FEAT_MASK (default bits 0, 8, 10 and 11), or paging_on is 1 and the write changes bit 8, the long-mode enable.
- R6: An accepted feature write leaves bit 10, the long-mode active bit, at its old value, whatever the write data holds.
- R7: The controller base register resets to 0xFEE00900. Bit 8 is the bootstrap flag, bit 11 is the global enable and bits 12 and up hold the base. A write made while the stored bit 11 is 1 keeps bits 31:0 of the value and pulses relocate for one cycle.
- R8: A write to the controller base register while the stored bit 11 is 0 is dropped. It does not fault and does not pulse relocate.
- R9: An address outside the map faults. If IGNORE_UNKNOWN is set, such a read instead returns zero with rd_valid, and such a write is dropped.
- R10: fault, rd_valid, rd_data and relocate are registered and appear in the cycle after the strobe. A faulting access never asserts rd_valid.
- R11: The address map starts at ADDR_BASE, which defaults to 0x200. The offsets are:
  - +0 code segment
  - +1 stack pointer
  - +2 instruction pointer
  - +3 legacy target
  - +4 long target
  - +5 compatibility target
  - +6 flag mask
  - +7 FS base
  - +8 GS base
  - +9 kernel-GS base
  - +10 auxiliary timestamp
  - +11 feature register
  - +12 controller base

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 32 | Register address |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| priv_lvl | input | 2 | Current privilege level |
| real_mode | input | 1 | Core is in real mode |
| paging_on | input | 1 | Paging is enabled |
| rd_data | output | 64 | Read result, registered |
| rd_valid | output | 1 | Read completed without fault |
| fault | output | 1 | One-cycle access fault |
| relocate | output | 1 | One-cycle pulse after an accepted controller base write |

## Verification
The assertions assume that rd_en and wr_en are never high in the same cycle, and that every access lasts exactly one cycle. The bench drives each strobe for a single cycle, one operation at a time, and then returns the strobes to zero before it samples the result. Random data is steered toward canonical values and toward supported feature bits often enough to reach both the accepting and the faulting paths. Random addresses include one outside the map.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter logic [31:0] ADDR_BASE      = 32'h0000_0200,
  parameter logic [63:0] FEAT_MASK      = 64'h0000_0000_0000_0D01,
  parameter int          LME_BIT        = 8,
  parameter int          LMA_BIT        = 10,
  parameter int          CANON_MSB      = 47,
  parameter int          CBASE_EN_BIT   = 11,
  parameter logic [63:0] CBASE_RESET    = 64'h0000_0000_FEE0_0900,
  parameter bit          IGNORE_UNKNOWN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] acc_addr,
  input  logic [63:0] wr_data,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  priv_lvl,
  input  logic        real_mode,
  input  logic        paging_on,
  output logic [63:0] rd_data,
  output logic        rd_valid,
  output logic        fault,
  output logic        relocate
);
  localparam int NREG    = 13;
  localparam int IW      = $clog2(NREG);
  localparam int I_CS    = 0;
  localparam int I_SP    = 1;
  localparam int I_IP    = 2;
  localparam int I_LEG   = 3;
  localparam int I_LONG  = 4;
  localparam int I_COMP  = 5;
  localparam int I_MASK  = 6;
  localparam int I_FS    = 7;
  localparam int I_GS    = 8;
  localparam int I_KGS   = 9;
  localparam int I_AUX   = 10;
  localparam int I_FEAT  = 11;
  localparam int I_CBASE = 12;
  localparam logic [63:0] LMA_MASK = 64'h1 << LMA_BIT;

  logic [63:0] regs [NREG];
  logic [31:0] off;
  logic [IW-1:0] idx;
  logic known, canon, priv_bad, wr_bad, do_fault, base_drop, wr_ok, rd_ok;
  logic [63:0] wr_val, rd_mux;

  assign off      = acc_addr - ADDR_BASE;
  assign known    = off < NREG;
  assign idx      = off[IW-1:0];
  assign canon    = (&wr_data[63:CANON_MSB]) | ~(|wr_data[63:CANON_MSB]);
  assign priv_bad = !real_mode && (priv_lvl != 2'd0);
  assign rd_mux   = known ? regs[idx] : 64'd0;

  always_comb begin
    wr_bad = 1'b0;
    wr_val = wr_data;
    case (idx)
      IW'(I_SP), IW'(I_IP), IW'(I_LONG), IW'(I_COMP),
      IW'(I_FS), IW'(I_GS), IW'(I_KGS):
        wr_bad = !canon;
      IW'(I_CS), IW'(I_MASK), IW'(I_AUX), IW'(I_CBASE):
        wr_val = {32'd0, wr_data[31:0]};
      IW'(I_FEAT): begin
        wr_bad = (|(wr_data & ~FEAT_MASK)) ||
                 (paging_on && (wr_data[LME_BIT] != regs[I_FEAT][LME_BIT]));
        wr_val = (wr_data & FEAT_MASK & ~LMA_MASK) | (regs[I_FEAT] & LMA_MASK);
      end
      default: ;
    endcase
  end

  assign do_fault  = (rd_en || wr_en) &&
                     (priv_bad || (!known && !IGNORE_UNKNOWN) || (wr_en && known && wr_bad));
  assign base_drop = (idx == IW'(I_CBASE)) && !regs[I_CBASE][CBASE_EN_BIT];
  assign wr_ok     = wr_en && known && !do_fault && !base_drop;
  assign rd_ok     = rd_en && !wr_en && !do_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == I_CBASE) ? CBASE_RESET : 64'd0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      fault    <= 1'b0;
      relocate <= 1'b0;
    end else begin
      if (wr_ok)
        regs[idx] <= wr_val;
      rd_valid <= rd_ok;
      rd_data  <= rd_ok ? rd_mux : 64'd0;
      fault    <= do_fault;
      relocate <= wr_ok && (idx == IW'(I_CBASE));
    end
  end
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter logic [31:0] ADDR_BASE      = 32'h0000_0200,
  parameter int          LME_BIT        = 8,
  parameter int          LMA_BIT        = 10,
  parameter int          CANON_MSB      = 47,
  parameter int          CBASE_EN_BIT   = 11,
  parameter bit          IGNORE_UNKNOWN = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] acc_addr,
  input logic [63:0] wr_data,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  priv_lvl,
  input logic        real_mode,
  input logic        paging_on,
  input logic        rd_valid,
  input logic        fault,
  input logic        relocate,
  input logic [63:0] feat_q,
  input logic [63:0] base_q
);
  logic canon_in, in_map;
  assign canon_in = (&wr_data[63:CANON_MSB]) | ~(|wr_data[63:CANON_MSB]);
  assign in_map   = (acc_addr >= ADDR_BASE) && (acc_addr < ADDR_BASE + 32'd13);

  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && !real_mode && priv_lvl != 2'd0 |=> fault); // R1
  AST_CANON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && acc_addr == ADDR_BASE + 32'd7 && !canon_in |=> fault); // R3
  AST_LME_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && acc_addr == ADDR_BASE + 32'd11 && paging_on && wr_data[LME_BIT] != feat_q[LME_BIT] |=> fault); // R5
  AST_LMA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && acc_addr == ADDR_BASE + 32'd11 |=> feat_q[LMA_BIT] == $past(feat_q[LMA_BIT])); // R6
  AST_RELOC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    relocate |-> $past(wr_en && acc_addr == ADDR_BASE + 32'd12 && base_q[CBASE_EN_BIT])); // R7
  AST_BASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && acc_addr == ADDR_BASE + 32'd12 && !base_q[CBASE_EN_BIT] |=> $stable(base_q) && !relocate); // R8
  AST_UNKNOWN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && !in_map && !IGNORE_UNKNOWN |=> fault); // R9
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !rd_valid); // R10
endmodule

bind sysreg_bank sysreg_bank_chk #(
  .ADDR_BASE(ADDR_BASE), .LME_BIT(LME_BIT), .LMA_BIT(LMA_BIT),
  .CANON_MSB(CANON_MSB), .CBASE_EN_BIT(CBASE_EN_BIT), .IGNORE_UNKNOWN(IGNORE_UNKNOWN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_data(wr_data),
  .rd_en(rd_en), .wr_en(wr_en), .priv_lvl(priv_lvl), .real_mode(real_mode),
  .paging_on(paging_on), .rd_valid(rd_valid), .fault(fault), .relocate(relocate),
  .feat_q(regs[11]), .base_q(regs[12])
);

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic        real_mode = 1'b0, paging_on = 1'b0;
  logic [63:0] rd_data;
  logic        rd_valid, fault, relocate;

  int checks = 0, errors = 0;
  logic [63:0] m [13];
  localparam logic [63:0] FMASK = 64'hD01;

  sysreg_bank u_sysreg_bank (.*);

  always #5 clk = ~clk;

  function automatic bit canon(logic [63:0] v);
    return (v[63:47] == '1) || (v[63:47] == '0);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 13; i++) m[i] = 64'd0;
    m[12] = 64'hFEE0_0900;
  endtask

  task automatic op(input string req, input bit w, input logic [31:0] a,
                    input logic [63:0] d, input logic [1:0] pr, input bit rl, input bit pg);
    bit ef, ev, er;
    logic [63:0] ed;
    int k;
    ef = 0; ev = 0; er = 0; ed = 0;
    k = int'(a) - 32'h200;
    if (!rl && pr != 0) ef = 1;
    else if (k < 0 || k > 12) ef = 1;
    else if (!w) begin ev = 1; ed = m[k]; end
    else begin
      case (k)
        0, 6, 10: m[k] = {32'd0, d[31:0]};
        1, 2, 4, 5, 7, 8, 9: if (canon(d)) m[k] = d; else ef = 1;
        3: m[k] = d;
        11: if ((d & ~FMASK) != 0 || (pg && d[8] != m[11][8])) ef = 1;
            else m[11] = (d & FMASK & ~64'h400) | (m[11] & 64'h400);
        default: if (m[12][11]) begin m[12] = {32'd0, d[31:0]}; er = 1; end
      endcase
    end
    @(negedge clk);
    acc_addr = a; wr_data = d; wr_en = w; rd_en = !w;
    priv_lvl = pr; real_mode = rl; paging_on = pg;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    checks++;
    if (fault !== ef || rd_valid !== ev || relocate !== er || (ev && rd_data !== ed)) begin
      errors++;
      $display("FAIL %s addr=%h: fault=%b valid=%b reloc=%b data=%h, expected fault=%b valid=%b reloc=%b data=%h",
               req, a, fault, rd_valid, relocate, rd_data, ef, ev, er, ed);
    end
  endtask

  task automatic rd(input string req, input logic [31:0] a);
    op(req, 0, a, 64'd0, 2'd0, 1'b0, 1'b0);
  endtask
  task automatic wr(input string req, input logic [31:0] a, input logic [63:0] d, input bit pg);
    op(req, 1, a, d, 2'd0, 1'b0, pg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [63:0] d;
    int k;
    seed = 32'd20251;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (fault !== 0 || rd_valid !== 0 || relocate !== 0) begin
      errors++;
      $display("FAIL R10 reset outputs: fault=%b valid=%b reloc=%b, expected 0 0 0", fault, rd_valid, relocate);
    end
    rd("R7 reset value", 32'h20C);
    rd("R11 reset zero", 32'h200);
    wr("R2", 32'h200, 64'hDEAD_BEEF_1234_5678, 0);
    rd("R2", 32'h200);
    wr("R3 noncanonical", 32'h207, 64'h0000_8000_0000_0000, 0);
    rd("R3", 32'h207);
    wr("R3 canonical", 32'h207, 64'hFFFF_8000_0000_0010, 0);
    rd("R3", 32'h207);
    wr("R3 kgs", 32'h209, 64'h7FFF_0000_0000_0000, 0);
    wr("R4 legacy", 32'h203, 64'h0123_4567_89AB_CDEF, 0);
    rd("R4", 32'h203);
    wr("R4 mask", 32'h206, 64'hFFFF_FFFF_0000_0F0F, 0);
    rd("R4", 32'h206);
    wr("R5 unsupported", 32'h20B, 64'h2, 0);
    wr("R5 lme under paging", 32'h20B, 64'h100, 1);
    wr("R5 lme no paging", 32'h20B, 64'h100, 0);
    wr("R5 lme same under paging", 32'h20B, 64'h901, 1);
    wr("R6 lma held", 32'h20B, 64'h500, 0);
    rd("R6", 32'h20B);
    op("R1 write priv", 1, 32'h203, 64'h55, 2'd3, 1'b0, 1'b0);
    op("R1 read priv", 0, 32'h203, 64'h0, 2'd1, 1'b0, 1'b0);
    op("R1 real mode ok", 0, 32'h203, 64'h0, 2'd3, 1'b1, 1'b0);
    rd("R9 unknown read", 32'h300);
    wr("R9 unknown write", 32'h1FF, 64'h1, 0);
    wr("R7 base move", 32'h20C, 64'h0000_0001_FEC0_0900, 0);
    rd("R7", 32'h20C);

    for (int n = 0; n < 400; n++) begin
      k = int'($urandom_range(0, 13));
      d = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) d[63:47] = {17{d[47]}};
      if (k == 11 && $urandom_range(0, 2) != 0) d = d & FMASK;
      if (k == 12) d[11] = 1'b1;
      op("R10 random", $urandom_range(0, 1) == 1, (k == 13) ? 32'h2F0 : 32'h200 + k, d,
         ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0,
         $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    wr("R7 clear enable", 32'h20C, 64'h0000_0000_FEB0_0000, 0);
    wr("R8 dropped", 32'h20C, 64'h0000_0000_FEE0_0900, 0);
    rd("R8", 32'h20C);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule